// File: doc/BRIEF.md
# Multi-Channel Line Violation Counter Bank

This block keeps one 16-bit violation tally for each of eight line channels. Each channel has a single-cycle violation strobe, and every strobe adds one to that channel's counter. A host reaches the bank through a small byte-wide register window. It never sees a live count.

The host first writes a channel number into the channel-select register. It then uses the control register to take a snapshot of that channel's counter into a per-channel holding register, or to clear the counter. The held value is read one byte at a time through the count register, and a byte-select bit in the control register picks the upper or lower half.

Counters stop at their maximum value and do not wrap. A clear that lands in the same cycle as a strobe takes priority. A channel number outside the bank selects nothing.

Top module: `vcnt_bank`

## Requirements
- R1: Each of the eight channels has its own counter, which adds one on every clock where that channel's strobe bit is 1. No other channel's strobe changes it.
- R2: Every counter and every holding register is 16 bits wide, and all of them are 0x0000 after reset.
- R3: The channel-select register sits at bus offset 0. A write stores write-data bits 3:0. A read returns them in bits 3:0 with bits 7:4 at zero. It resets to 0.
- R4: The control register sits at bus offset 1. Bit 2 is byte select, bit 1 is update and bit 0 is clear. It reads back in bits 2:0 with bits 7:3 at zero, and all three bits are 0 after reset.
- R5: A control write with bit 1 set, while the stored update bit is 0, copies the selected channel's count into its holding register. The copied value is the count just before that write's clock edge, and the copy happens at that same edge. A holding register changes at no other time.
- R6: While the stored clear bit is 1 and the selected channel is valid, that channel's counter is forced to 0x0000 on every clock edge. The first forced edge is the one after the write edge.
- R7: At offset 2, the count register returns bits 7:0 of the selected channel's held value when byte select is 0, and bits 15:8 when it is 1.
- R8: Reads are combinational from the address: rdata follows the current offset and register state with no clock delay. Offset 3 reads 0x00.
- R9: An update fires only when the stored update bit goes from 0 to 1. Rewriting bit 1 as 1 while it is already 1 takes no new snapshot.
- R10: A counter at 0xFFFF stays at 0xFFFF on further strobes.
- R11: If a strobe and an active clear meet in the same cycle, the counter is 0x0000 after that edge.
- R12: A channel number of 8 or more selects no channel. Update and clear have no effect, and the count register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| viol_strb | input | 8 | One violation pulse bit per channel |
| bus_wr | input | 1 | Write enable for the register window |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |

## Verification
Register writes and counter steps take effect at the clock edge where they are presented. A snapshot holds the count from before that same edge. A clear first forces zero one edge after its write, because it acts from the stored bit. Read data depends combinationally on the address, so a value is due in the cycle after the edge that changed its source.

The bench drives inputs on the falling edge and advances its reference model on the rising edge. It compares bus_rdata with the model's prediction 1 ns after each falling edge, when every path has settled. Directed reads at the same point check concrete values taken from the requirements.

// File: rtl/vcnt_pkg.sv
package vcnt_pkg;
   localparam int          REG_AW     = 2;
   localparam logic [1:0]  RA_CHSEL   = 2'd0;
   localparam logic [1:0]  RA_CTRL    = 2'd1;
   localparam logic [1:0]  RA_COUNT   = 2'd2;
   localparam int          CB_CLR     = 0;
   localparam int          CB_UPD     = 1;
   localparam int          CB_BSEL    = 2;
   localparam int          CTRL_W     = 3;

   typedef struct packed {
      logic bsel;
      logic upd;
      logic clr;
   } ctrl_t;
endpackage

// File: rtl/vcnt_regs.sv
module vcnt_regs
   import vcnt_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int DATA_W = 8,
   parameter int CHA_W  = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [REG_AW-1:0]     addr,
   input  logic [DATA_W-1:0]     wdata,
   output logic [CHA_W-1:0]      sel_q,
   output ctrl_t                 ctrl_q,
   output logic                  sel_valid,
   output logic [NUM_CH-1:0]     upd_vec,
   output logic [NUM_CH-1:0]     clr_vec
);
   logic upd_pulse;
   logic wr_sel, wr_ctrl;
   logic unused_hi;

   assign unused_hi = &{1'b0, wdata[DATA_W-1:CHA_W]};
   assign wr_sel    = wr_en && (addr == RA_CHSEL);
   assign wr_ctrl   = wr_en && (addr == RA_CTRL);
   assign upd_pulse = wr_ctrl && wdata[CB_UPD] && !ctrl_q.upd;
   assign sel_valid = (int'(sel_q) < NUM_CH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= '0;
         ctrl_q <= '0;
      end else begin
         if (wr_sel)
            sel_q <= wdata[CHA_W-1:0];
         if (wr_ctrl) begin
            ctrl_q.bsel <= wdata[CB_BSEL];
            ctrl_q.upd  <= wdata[CB_UPD];
            ctrl_q.clr  <= wdata[CB_CLR];
         end
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
      assign upd_vec[c] = upd_pulse   && sel_valid && (sel_q == CHA_W'(c));
      assign clr_vec[c] = ctrl_q.clr  && sel_valid && (sel_q == CHA_W'(c));
   end

   AST_UPD_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_vec != '0) |=> (upd_vec == '0));                          // R9
   AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr_vec) && $onehot0(upd_vec));                       // R6
endmodule

// File: rtl/vcnt_chan.sv
module vcnt_chan #(
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe,
   input  logic             clr,
   input  logic             snap,
   output logic [CNT_W-1:0] hold_q
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;

   if (SATURATE) begin : g_sat
      assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
   end else begin : g_wrap
      assign cnt_inc = cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (strobe)
         cnt_q <= cnt_inc;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hold_q <= '0;
      else if (snap)
         hold_q <= cnt_q;
   end

   AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));                                        // R11
   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !strobe) |=> $stable(cnt_q));                         // R1
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !snap |=> $stable(hold_q));                                    // R5
   if (SATURATE) begin : g_sat_chk
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_q == CNT_MAX && !clr) |=> (cnt_q == CNT_MAX));         // R10
   end
endmodule

// File: rtl/vcnt_rdmux.sv
module vcnt_rdmux
   import vcnt_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int CNT_W  = 16,
   parameter int DATA_W = 8,
   parameter int CHA_W  = 4
) (
   input  logic [NUM_CH*CNT_W-1:0] hold_flat,
   input  logic [CHA_W-1:0]        sel_q,
   input  logic                    sel_valid,
   input  ctrl_t                   ctrl_q,
   input  logic [REG_AW-1:0]       addr,
   output logic [DATA_W-1:0]       rdata
);
   logic [CNT_W-1:0]  held_sel;
   logic [DATA_W-1:0] byte_out;

   always_comb begin
      held_sel = '0;
      for (int c = 0; c < NUM_CH; c++)
         if (sel_valid && sel_q == CHA_W'(c))
            held_sel = hold_flat[c*CNT_W +: CNT_W];
   end

   assign byte_out = ctrl_q.bsel ? held_sel[CNT_W-1 -: DATA_W] : held_sel[DATA_W-1:0];

   always_comb begin
      unique case (addr)
         RA_CHSEL: rdata = DATA_W'(sel_q);
         RA_CTRL:  rdata = DATA_W'(ctrl_q);
         RA_COUNT: rdata = sel_valid ? byte_out : '0;
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/vcnt_bank.sv
module vcnt_bank
   import vcnt_pkg::*;
#(
   parameter int NUM_CH   = 8,
   parameter int CNT_W    = 16,
   parameter int DATA_W   = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CH-1:0]    viol_strb,
   input  logic                 bus_wr,
   input  logic [REG_AW-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata
);
   localparam int CHA_W = 4;

   if (NUM_CH < 1 || NUM_CH > (1 << CHA_W)) begin : g_bad_ch
      $error("vcnt_bank: NUM_CH must lie in 1..16");
   end
   if (CNT_W != 2 * DATA_W) begin : g_bad_w
      $error("vcnt_bank: CNT_W must be twice DATA_W");
   end
   if (DATA_W < CHA_W + 1) begin : g_bad_d
      $error("vcnt_bank: DATA_W too narrow for the register fields");
   end

   logic [CHA_W-1:0]        sel_q;
   ctrl_t                   ctrl_q;
   logic                    sel_valid;
   logic [NUM_CH-1:0]       upd_vec;
   logic [NUM_CH-1:0]       clr_vec;
   logic [NUM_CH*CNT_W-1:0] hold_flat;

   vcnt_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CHA_W(CHA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (bus_wr),
      .addr      (bus_addr),
      .wdata     (bus_wdata),
      .sel_q     (sel_q),
      .ctrl_q    (ctrl_q),
      .sel_valid (sel_valid),
      .upd_vec   (upd_vec),
      .clr_vec   (clr_vec)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      vcnt_chan #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .strobe (viol_strb[c]),
         .clr    (clr_vec[c]),
         .snap   (upd_vec[c]),
         .hold_q (hold_flat[c*CNT_W +: CNT_W])
      );
   end

   vcnt_rdmux #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W), .CHA_W(CHA_W)) u_rdmux (
      .hold_flat (hold_flat),
      .sel_q     (sel_q),
      .sel_valid (sel_valid),
      .ctrl_q    (ctrl_q),
      .addr      (bus_addr),
      .rdata     (bus_rdata)
   );

   AST_NOSEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_valid && bus_addr == RA_COUNT) |-> (bus_rdata == '0));   // R12
   AST_NOSEL_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_valid |=> $stable(hold_flat));                            // R12
   AST_HI_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == 2'd3) |-> (bus_rdata == '0));                     // R8
endmodule

// File: tb/vcnt_bank_tb.sv
`timescale 1ns/1ps
module vcnt_bank_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] viol_strb = '0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;

   int n_chk = 0;
   int n_err = 0;

   // reference model state
   int m_cnt  [8];
   int m_hold [8];
   int m_sel  = 0;
   int m_ctrl = 0;

   vcnt_bank u_dut (
      .clk(clk), .rst_n(rst_n), .viol_strb(viol_strb), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   always #2.5 clk = ~clk;

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int predict(input int a);
      int v;
      case (a)
         0: v = m_sel;
         1: v = m_ctrl;
         2: begin
            if (m_sel < 8) v = ((m_ctrl >> 2) & 1) ? (m_hold[m_sel] >> 8) & 255 : m_hold[m_sel] & 255;
            else v = 0;
         end
         default: v = 0;
      endcase
      return v;
   endfunction

   // model advance on the rising edge; inputs change only on falling edges
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < 8; c++) begin m_cnt[c] = 0; m_hold[c] = 0; end
         m_sel = 0; m_ctrl = 0;
      end else begin
         automatic bit vld = (m_sel < 8);
         automatic bit upd = bus_wr && bus_addr == 2'd1 && bus_wdata[1] && !m_ctrl[1];
         if (upd && vld) m_hold[m_sel] = m_cnt[m_sel];
         for (int c = 0; c < 8; c++) begin
            if (m_ctrl[0] && vld && m_sel == c) m_cnt[c] = 0;
            else if (viol_strb[c] && m_cnt[c] < 65535) m_cnt[c]++;
         end
         if (bus_wr && bus_addr == 2'd0) m_sel = int'(bus_wdata[3:0]);
         if (bus_wr && bus_addr == 2'd1) m_ctrl = int'(bus_wdata[2:0]);
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         #1;
         begin
            automatic int e = predict(int'(bus_addr));
            automatic string t = (bus_addr == 0) ? "R3" : (bus_addr == 1) ? "R4" :
                                 (bus_addr == 2) ? "R7" : "R8";
            chk(bus_rdata == 8'(e), t, int'(bus_rdata), e);
         end
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 2'd2;
   endtask

   task automatic rd(input logic [1:0] a, input int exp, input string tag);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(bus_rdata == 8'(exp), tag, int'(bus_rdata), exp);
   endtask

   task automatic pulses(input int ch, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); viol_strb[ch] = 1'b1;
      end
      @(negedge clk); viol_strb = '0;
   endtask

   task automatic snap_read(input int ch, input int exp, input string tag);
      wr(2'd0, 8'(ch));
      wr(2'd1, 8'h00);
      wr(2'd1, 8'h02);
      rd(2'd2, exp & 255, tag);
      wr(2'd1, 8'h06);
      rd(2'd2, (exp >> 8) & 255, tag);
   endtask

   initial begin
      bus_addr = 2'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state
      rd(2'd0, 0, "R3_reset");
      rd(2'd1, 0, "R4_reset");
      rd(2'd2, 0, "R2_reset");
      rd(2'd3, 0, "R8");
      // register readback masks
      wr(2'd0, 8'hF6); rd(2'd0, 6, "R3");
      wr(2'd1, 8'hF8); rd(2'd1, 0, "R4");
      wr(2'd1, 8'h00);
      // basic count and snapshot on ch2
      pulses(2, 5);
      snap_read(2, 5, "R5");
      // update held high: no new snapshot (R9)
      pulses(2, 3);
      wr(2'd1, 8'h02); rd(2'd2, 5, "R9");
      wr(2'd1, 8'h00); wr(2'd1, 8'h02); rd(2'd2, 8, "R9");
      // two-byte value on ch5, independence from ch0 (R1, R2, R7)
      pulses(5, 300);
      pulses(0, 7);
      snap_read(5, 300, "R7");
      snap_read(0, 7, "R1");
      snap_read(2, 8, "R1");
      // clear held ~1 us while strobing the same channel (R6, R11)
      wr(2'd0, 8'd5); wr(2'd1, 8'h01);
      pulses(5, 200);
      wr(2'd1, 8'h00);
      snap_read(5, 0, "R11");
      pulses(5, 4);
      snap_read(5, 4, "R6");
      // invalid channel: no effect, reads zero (R12)
      wr(2'd0, 8'd9);
      wr(2'd1, 8'h02); rd(2'd2, 0, "R12");
      wr(2'd1, 8'h01); repeat (5) @(negedge clk); wr(2'd1, 8'h00);
      snap_read(2, 8, "R12");
      // saturation on ch3 (R10)
      pulses(3, 65600);
      snap_read(3, 65535, "R10");
      rd(2'd3, 0, "R8");
      repeat (3) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule